// File: doc/BRIEF.md
# Slot Word G.711 Compander Stage

This stage sits in the data path of a serial audio block. On the transmit side it sits between the sample queue and the serial shift register. On the receive side it sits between the shift register and the queue. When the transmit direction is selected, it turns a 16-bit linear sample into an 8-bit G.711 code word. It places that code word at the most significant end of the 32-bit slot word. When the receive direction is selected, it takes the code word from the top byte of the slot word and rebuilds a 16-bit linear sample.

A two-bit law selector chooses between pass-through, µ-law and A-law. A complement select picks one's or two's complement for the linear side. Companding takes effect only when all three of these hold:
- the stage is enabled;
- the free slot-based protocol is in use;
- a law is selected.

The stage also reports the data size that the serial logic should use. It forces the 8-bit size code whenever a law is selected on an enabled block.

Each transfer goes through a single output register that uses valid/ready handshakes on both sides. A word accepted on one clock edge is offered on the next edge. It is held there until the consumer takes it.

Top module: `audio_compand_stage`

## Requirements
- R1: When `law_sel[1]` is 0, the output word equals the accepted input word bit for bit, in both directions.
- R2: When `enable` is 0 or `proto_free` is 0, the output word equals the accepted input word, whatever `law_sel` holds.
- R3: µ-law compression (`law_sel`=10, `dir_rx`=0) works as follows. The linear sample is taken from input bits [15:0] and reduced to 14 bits. A bias of 33 is added to its magnitude. The code is the bitwise inverse of {sign, 3-bit segment, 4-bit step}. The code goes out on bits [31:24], with bits [23:0] zero. Input bits [31:16] have no effect.
- R4: A-law compression (`law_sel`=11, `dir_rx`=0) works as follows. The linear sample is taken from input bits [15:0] and reduced to 13 bits. The code is {not sign, segment, step} XOR 0x55. It is placed on bits [31:24], with bits [23:0] zero. Input bits [31:16] have no effect.
- R5: A linear magnitude beyond the selected law's range yields segment 7 and step 15. In µ-law the limit is a 14-bit magnitude of 8158; in A-law it is a 13-bit magnitude of 4095.
- R6: µ-law expansion (`law_sel`=10, `dir_rx`=1) takes the code from input bits [31:24]. It returns the magnitude ((8·step+132)·2^segment − 132) on output bits [15:0], with output bits [31:16] zero. Input bits [23:0] have no effect.
- R7: A-law expansion (`law_sel`=11, `dir_rx`=1) first XORs the code with 0x55. For segment 0 it returns the magnitude 16·step+8; for other segments it returns (16·step+264)·2^(segment−1). The result goes on output bits [15:0].
- R8: `cpl_twos`=1 selects two's complement for linear values in both directions; `cpl_twos`=0 selects one's complement. A negative value is written as −magnitude or as the bitwise inverse of the magnitude, respectively.
- R9: `eff_size` is 3'b010 while `enable` and `law_sel[1]` are both 1; otherwise it equals `cfg_size`.
- R10: A word accepted on a clock edge is presented with `out_valid` high after that edge. `in_ready` is high whenever the output register is empty or being drained. A stalled output holds its data, and every accepted word leaves exactly once, in order.
- R11: During and right after reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Audio block enable |
| proto_free | input | 1 | 1 when the free slot-based protocol is in use |
| dir_rx | input | 1 | 0 = compress (transmit), 1 = expand (receive) |
| law_sel | input | 2 | 00/01 pass, 10 µ-law, 11 A-law |
| cpl_twos | input | 1 | 1 = two's complement linear, 0 = one's complement |
| cfg_size | input | 3 | Configured data size code |
| eff_size | output | 3 | Data size code in effect |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Stage can accept a word |
| in_data | input | 32 | Input slot word |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Consumer takes the output word |
| out_data | output | 32 | Output slot word |

## Verification
The bench drives both laws in both directions with these corner inputs:
- the most positive and most negative linear samples, which a missing clip would wrap into small codes;
- negative zero and minus one, where mixing up one's and two's complement shifts every negative result by one step;
- all-zero and all-one codes, which exercise the extreme segments of the decoders.

Junk in the unused halves of the slot word exposes a stage that reads the wrong byte or fails to clear the low bits. Random back-pressure on `out_ready` catches a register that drops or repeats a word under stall. Mixing the enable, protocol and law inputs catches a gate that compands when it should pass data through.

// File: rtl/compand_pkg.sv
package compand_pkg;
  localparam int SLOT_W = 32;
  localparam int LIN_W  = 16;
  localparam int CODE_W = 8;
  localparam int SEG_W  = 3;
  localparam int STEP_W = 4;
  localparam int SIZE_W = 3;

  localparam logic [SIZE_W-1:0] SIZE_8BIT = 3'b010;
  localparam logic [CODE_W-1:0] A_XOR     = 8'h55;
  localparam logic [13:0]       MU_CLIP   = 14'd8158;
  localparam logic [13:0]       MU_BIAS   = 14'd33;
  localparam logic [15:0]       MU_OFFS   = 16'd132;
  localparam logic [15:0]       A_OFFS    = 16'd264;

  typedef enum logic [1:0] {
    LAW_OFF  = 2'b00,
    LAW_RSV  = 2'b01,
    LAW_MU   = 2'b10,
    LAW_A    = 2'b11
  } law_e;
endpackage

// File: rtl/g711_encoder.sv
module g711_encoder
  import compand_pkg::*;
(
  input  logic [LIN_W-1:0]  lin,
  input  logic              law_a,
  input  logic              twos,
  output logic [CODE_W-1:0] code
);
  logic              neg;
  logic [13:0]       mu_mag, mu_b;
  logic [SEG_W-1:0]  mu_seg, a_seg;
  logic [STEP_W-1:0] mu_step, a_step;
  logic [12:0]       a_mag;
  logic [11:0]       a_clip;

  assign neg = lin[LIN_W-1];

  // mu-law: 14-bit linear, clip, bias, segment search
  always_comb begin
    if (neg) mu_mag = twos ? 14'(-lin[15:2]) : ~lin[15:2];
    else     mu_mag = lin[15:2];
    mu_b   = ((mu_mag > MU_CLIP) ? MU_CLIP : mu_mag) + MU_BIAS;
    mu_seg = '0;
    for (int i = 0; i < 8; i++) begin
      if (mu_b[5+i]) mu_seg = SEG_W'(i);
    end
    mu_step = STEP_W'(mu_b >> (4'(mu_seg) + 4'd1));
  end

  // A-law: 13-bit linear, clip, segment search
  always_comb begin
    if (neg) a_mag = twos ? 13'(-lin[15:3]) : ~lin[15:3];
    else     a_mag = lin[15:3];
    a_clip = a_mag[12] ? 12'hFFF : a_mag[11:0];
    a_seg  = '0;
    for (int i = 1; i < 8; i++) begin
      if (a_clip[4+i]) a_seg = SEG_W'(i);
    end
    a_step = (a_seg == '0) ? a_clip[4:1] : STEP_W'(a_clip >> a_seg);
  end

  assign code = law_a ? ({~neg, a_seg, a_step} ^ A_XOR)
                      : ~{neg, mu_seg, mu_step};
endmodule

// File: rtl/g711_decoder.sv
module g711_decoder
  import compand_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  input  logic              law_a,
  input  logic              twos,
  output logic [LIN_W-1:0]  lin
);
  logic [CODE_W-1:0] c_mu, c_a;
  logic [LIN_W-1:0]  mu_mag, a_mag, mag;
  logic              neg;

  always_comb begin
    c_mu   = ~code;
    mu_mag = ((LIN_W'({c_mu[3:0], 3'b000}) + MU_OFFS) << c_mu[6:4]) - MU_OFFS;
    c_a    = code ^ A_XOR;
    if (c_a[6:4] == '0)
      a_mag = LIN_W'({c_a[3:0], 4'b1000});
    else
      a_mag = (LIN_W'({c_a[3:0], 4'b0000}) + A_OFFS) << (c_a[6:4] - 3'd1);
    mag = law_a ? a_mag : mu_mag;
    neg = law_a ? ~c_a[7] : c_mu[7];
    if (neg) lin = twos ? (-mag) : (~mag);
    else     lin = mag;
  end
endmodule

// File: rtl/cmp_pipe_stage.sv
module cmp_pipe_stage #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic         vld_q, vld_nxt, load;
  logic [W-1:0] data_q;

  always_comb begin
    in_ready = !vld_q || out_ready;
    load     = in_valid && in_ready;
    if (load)           vld_nxt = 1'b1;
    else if (out_ready) vld_nxt = 1'b0;
    else                vld_nxt = vld_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_nxt;
  end

  always_ff @(posedge clk) begin
    if (load) data_q <= in_data;
  end

  assign out_valid = vld_q;
  assign out_data  = data_q;
endmodule

// File: rtl/audio_compand_stage.sv
module audio_compand_stage
  import compand_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              proto_free,
  input  logic              dir_rx,
  input  logic [1:0]        law_sel,
  input  logic              cpl_twos,
  input  logic [SIZE_W-1:0] cfg_size,
  output logic [SIZE_W-1:0] eff_size,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [SLOT_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [SLOT_W-1:0] out_data
);
  localparam int PAD_TX = SLOT_W - CODE_W;
  localparam int PAD_RX = SLOT_W - LIN_W;

  logic              law_on, apply, law_a;
  logic [CODE_W-1:0] enc_code;
  logic [LIN_W-1:0]  dec_lin;
  logic [SLOT_W-1:0] word_nxt;

  assign law_on   = enable && law_sel[1];
  assign apply    = law_on && proto_free;
  assign law_a    = (law_e'(law_sel) == LAW_A);
  assign eff_size = law_on ? SIZE_8BIT : cfg_size;

  g711_encoder u_enc (
    .lin   (in_data[LIN_W-1:0]),
    .law_a (law_a),
    .twos  (cpl_twos),
    .code  (enc_code)
  );

  g711_decoder u_dec (
    .code  (in_data[SLOT_W-1 -: CODE_W]),
    .law_a (law_a),
    .twos  (cpl_twos),
    .lin   (dec_lin)
  );

  always_comb begin
    if (!apply)      word_nxt = in_data;
    else if (dir_rx) word_nxt = {{PAD_RX{1'b0}}, dec_lin};
    else             word_nxt = {enc_code, {PAD_TX{1'b0}}};
  end

  cmp_pipe_stage #(.W(SLOT_W)) u_pipe (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (word_nxt),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
  );
endmodule

// File: rtl/audio_compand_stage_chk.sv
module audio_compand_stage_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        enable,
  input logic        proto_free,
  input logic        dir_rx,
  input logic [1:0]  law_sel,
  input logic [2:0]  cfg_size,
  input logic [2:0]  eff_size,
  input logic        in_valid,
  input logic        in_ready,
  input logic [31:0] in_data,
  input logic        out_valid,
  input logic        out_ready,
  input logic [31:0] out_data
);
  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !(enable && proto_free && law_sel[1]))
      |=> (out_data == $past(in_data))); // R1

  AST_TX_LOW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && enable && proto_free && law_sel[1] && !dir_rx)
      |=> (out_data[23:0] == 24'd0)); // R3

  AST_RX_HIGH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && enable && proto_free && law_sel[1] && dir_rx)
      |=> (out_data[31:16] == 16'd0)); // R6

  AST_SIZE_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && law_sel[1]) |-> (eff_size == 3'b010)); // R9

  AST_SIZE_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    !(enable && law_sel[1]) |-> (eff_size == cfg_size)); // R9

  AST_ACCEPT_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid); // R10

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R10

  AST_EMPTY_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready); // R11
endmodule

bind audio_compand_stage audio_compand_stage_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .enable     (enable),
  .proto_free (proto_free),
  .dir_rx     (dir_rx),
  .law_sel    (law_sel),
  .cfg_size   (cfg_size),
  .eff_size   (eff_size),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_data    (in_data),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_data   (out_data)
);

// File: tb/tb_audio_compand_stage.sv
`timescale 1ns/1ps
module tb_audio_compand_stage;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        enable, proto_free, dir_rx, cpl_twos;
  logic [1:0]  law_sel;
  logic [2:0]  cfg_size, eff_size;
  logic        in_valid, in_ready, out_valid, out_ready;
  logic [31:0] in_data, out_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] exp_q [0:4095];
  string       tag_q [0:4095];
  int wr_ptr = 0;
  int rd_ptr = 0;

  always #2 clk = ~clk;

  audio_compand_stage dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .proto_free(proto_free),
    .dir_rx(dir_rx), .law_sel(law_sel), .cpl_twos(cpl_twos),
    .cfg_size(cfg_size), .eff_size(eff_size),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  function automatic logic [15:0] put_sign(logic neg, int mag, logic twos);
    if (!neg)     return 16'(mag);
    else if (twos) return 16'(-mag);
    else          return 16'(~mag);
  endfunction

  function automatic logic [7:0] ref_mu_enc(logic [15:0] x, logic twos);
    int v, mag, seg, step;
    v = int'($signed(x)) >>> 2;
    if (!x[15])    mag = v;
    else if (twos) mag = -v;
    else           mag = -v - 1;
    if (mag > 8158) mag = 8158;
    mag = mag + 33;
    seg = 0;
    while (seg < 7 && mag >= (64 << seg)) seg++;
    step = (mag >> (seg + 1)) & 15;
    return ~{x[15], 3'(seg), 4'(step)};
  endfunction

  function automatic logic [7:0] ref_a_enc(logic [15:0] x, logic twos);
    int v, mag, seg, step;
    v = int'($signed(x)) >>> 3;
    if (!x[15])    mag = v;
    else if (twos) mag = -v;
    else           mag = -v - 1;
    if (mag > 4095) mag = 4095;
    if (mag < 32) begin
      seg = 0; step = mag >> 1;
    end else begin
      seg = 1;
      while (seg < 7 && mag >= (64 << (seg - 1))) seg++;
      step = (mag >> seg) & 15;
    end
    return {~x[15], 3'(seg), 4'(step)} ^ 8'h55;
  endfunction

  function automatic logic [15:0] ref_mu_dec(logic [7:0] c, logic twos);
    logic [7:0] u;
    int mag;
    u = ~c;
    mag = 4 * ((2 * int'(u[3:0]) + 33) * (1 << int'(u[6:4])) - 33);
    return put_sign(u[7], mag, twos);
  endfunction

  function automatic logic [15:0] ref_a_dec(logic [7:0] c, logic twos);
    logic [7:0] u;
    int mag;
    u = c ^ 8'h55;
    if (u[6:4] == 3'd0) mag = 16 * int'(u[3:0]) + 8;
    else                mag = (16 * int'(u[3:0]) + 264) * (1 << (int'(u[6:4]) - 1));
    return put_sign(!u[7], mag, twos);
  endfunction

  function automatic logic [31:0] ref_word(logic [31:0] d, logic en, logic pf,
                                           logic [1:0] lw, logic rx, logic twos);
    if (!(en && pf && lw[1])) return d;
    if (rx) return {16'd0, lw[0] ? ref_a_dec(d[31:24], twos) : ref_mu_dec(d[31:24], twos)};
    return {lw[0] ? ref_a_enc(d[15:0], twos) : ref_mu_enc(d[15:0], twos), 24'd0};
  endfunction

  function automatic logic [15:0] corner_lin(int k);
    case (k % 8)
      0: return 16'h7FFF;
      1: return 16'h8000;
      2: return 16'h0000;
      3: return 16'hFFFF;
      4: return 16'h7F00;
      5: return 16'hC000;
      6: return 16'h0084;
      default: return 16'hFF7B;
    endcase
  endfunction

  function automatic logic [7:0] corner_code(int k);
    case (k % 8)
      0: return 8'h00;
      1: return 8'hFF;
      2: return 8'h80;
      3: return 8'h7F;
      4: return 8'h55;
      5: return 8'hD5;
      6: return 8'h2A;
      default: return 8'hAA;
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    int idx, sent;
    bit took_last, need_valid_chk, is_corner;
    string tag;
    void'($urandom(32'h5EED_0711));
    rst_n = 1'b0; enable = 1'b0; proto_free = 1'b0; dir_rx = 1'b0;
    cpl_twos = 1'b0; law_sel = 2'b00; cfg_size = 3'b100;
    in_valid = 1'b0; in_data = '0; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    check("R11 out_valid in reset", {31'd0, out_valid}, 32'd0);
    check("R11 in_ready in reset", {31'd0, in_ready}, 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 out_valid after reset", {31'd0, out_valid}, 32'd0);
    check("R11 in_ready after reset", {31'd0, in_ready}, 32'd1);

    idx = 0; sent = 0; took_last = 1'b1; need_valid_chk = 1'b0;
    for (int cyc = 0; cyc < 6000; cyc++) begin
      @(negedge clk);
      if (need_valid_chk) check("R10 word visible after accept", {31'd0, out_valid}, 32'd1);
      if (!in_valid || took_last) begin
        if (idx < 64) begin
          enable = 1'b1; proto_free = 1'b1;
          dir_rx = idx[3]; law_sel = {1'b1, idx[4]}; cpl_twos = idx[5];
          in_data = dir_rx ? {corner_code(idx), 24'($urandom)}
                           : {16'($urandom), corner_lin(idx)};
          in_valid = 1'b1;
          idx++;
        end else if (idx < 3064) begin
          enable = ($urandom % 8) != 0;
          proto_free = ($urandom % 8) != 0;
          dir_rx = 1'($urandom); cpl_twos = 1'($urandom);
          law_sel = 2'($urandom);
          in_data = $urandom;
          if (($urandom % 2) != 0) in_data[15:0] = 16'($signed(12'($urandom)));
          in_valid = ($urandom % 4) != 0;
          if (in_valid) idx++;
        end else begin
          in_valid = 1'b0;
        end
        cfg_size = 3'($urandom);
      end
      out_ready = ($urandom % 3) != 0;
      #1;
      check("R9 effective size", {29'd0, eff_size},
            {29'd0, (enable && law_sel[1]) ? 3'b010 : cfg_size});
      if (out_valid && out_ready) begin
        if (rd_ptr < wr_ptr) begin
          check(tag_q[rd_ptr % 4096], out_data, exp_q[rd_ptr % 4096]);
          rd_ptr++;
        end else begin
          check("R10 unexpected extra word", 32'd1, 32'd0);
        end
      end
      took_last = in_valid && in_ready;
      need_valid_chk = took_last;
      if (took_last) begin
        is_corner = (idx <= 64) && !dir_rx && (((idx - 1) % 8) < 2);
        if (!law_sel[1])                  tag = "R1 pass-through";
        else if (!(enable && proto_free)) tag = "R2 gated off";
        else if (is_corner)               tag = "R5/R8 saturation";
        else if (dir_rx)                  tag = law_sel[0] ? "R7/R8 A-law expand" : "R6/R8 mu-law expand";
        else                              tag = law_sel[0] ? "R4/R8 A-law compress" : "R3/R8 mu-law compress";
        exp_q[wr_ptr % 4096] = ref_word(in_data, enable, proto_free, law_sel, dir_rx, cpl_twos);
        tag_q[wr_ptr % 4096] = tag;
        wr_ptr++;
        sent++;
      end
      if (idx >= 3064 && !in_valid && rd_ptr == wr_ptr && !out_valid) break;
    end
    check("R10 words out equal words in", 32'(rd_ptr), 32'(sent));
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule